// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Per-Port Burst Address Counters

This block is a true dual-port synchronous static RAM shared by two fully independent ports, left and right, in a single clock domain. Each port can read or write any word in the array on every clock edge, including the word the other port is using. The production configuration is 13 address bits and 9 data bits (8192 words). The default elaboration uses 11 address bits to keep the array small, and every width is a parameter.

Each port carries its own burst address counter, driven by three active-low controls: counter clear, address strobe and count enable. On every rising edge the counter takes one of four named operations, in fixed priority: CNT_CLEAR, CNT_LOAD, CNT_HOLD, CNT_STEP. The value it takes is the internal address that the port reads or writes in that same cycle. A port also chooses its read latency. In flow-through mode the read word is presented after the edge that sampled the address. In pipelined mode it passes through one more register. The data outputs come as a word plus a drive-enable flag. The drive-enable flag stands in for a tri-state bus: when it is low, the word is forced to zero.

Top module: `dpr_burst_ram`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits, and both ports may read or write any address in the same cycle, each port seeing the contents as of that edge.
- R2: A port is selected only when its `ce0_n` is 0 and its `ce1` is 1. A deselected port neither writes the array nor captures a read, so its drive-enable stays 0 for the matching output cycle.
- R3: On a rising edge a selected port reads when `rw` is 1 and writes `wdata` when `rw` is 0. A write cycle never raises the drive-enable.
- R4: With `pipe` = 0 (flow-through), a read captured on edge k drives its word and sets `rdata_oe` from just after edge k until edge k+1.
- R5: With `pipe` = 1 (pipelined), a read captured on edge k appears from just after edge k+1 until edge k+2.
- R6: `oe_n` = 1 forces `rdata_oe` to 0 and `rdata` to 0 combinationally, without waiting for a clock edge.
- R7: The counter operation is chosen in strict priority: `cntrst_n` = 0 clears it to 0 (CNT_CLEAR); else `ads_n` = 0 loads `addr` (CNT_LOAD); else `cnten_n` = 1 keeps it (CNT_HOLD); else it adds one (CNT_STEP). The chip enables have no effect on the counter.
- R8: When `ads_n` = 0 and `cntrst_n` = 1, the internal address used in that cycle is `addr`. When `ads_n` = 1, it is the counter's new value.
- R9: A counter clear costs no cycle: a read or write in the clearing cycle uses address 0.
- R10: Stepping from address 2^ADDR_W−1 wraps the counter to 0.
- R11: If both ports write the same address on one edge, the left port's data is stored.
- R12: A read of an address that the other port writes on the same edge returns the old contents. A read on the next edge returns the new data.
- R13: While `rst_n` = 0, both counters clear to 0 and both read stages are emptied. After reset, a hold-mode access uses address 0 and no output is driven until a read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst_n | input | 1 | Active-low reset for counters and read stages |
| l_addr | input | ADDR_W | Left external address |
| l_wdata | input | DATA_W | Left write data |
| l_rw | input | 1 | Left: 1 = read, 0 = write |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_oe_n | input | 1 | Left output enable, active low |
| l_pipe | input | 1 | Left latency: 0 = flow-through, 1 = pipelined |
| l_ads_n | input | 1 | Left address strobe (load), active low |
| l_cnten_n | input | 1 | Left count enable, active low |
| l_cntrst_n | input | 1 | Left counter clear, active low |
| l_rdata | output | DATA_W | Left read word (0 when not driven) |
| l_rdata_oe | output | 1 | Left drive-enable |
| r_addr | input | ADDR_W | Right external address |
| r_wdata | input | DATA_W | Right write data |
| r_rw | input | 1 | Right: 1 = read, 0 = write |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_oe_n | input | 1 | Right output enable, active low |
| r_pipe | input | 1 | Right latency: 0 = flow-through, 1 = pipelined |
| r_ads_n | input | 1 | Right address strobe (load), active low |
| r_cnten_n | input | 1 | Right count enable, active low |
| r_cntrst_n | input | 1 | Right counter clear, active low |
| r_rdata | output | DATA_W | Right read word (0 when not driven) |
| r_rdata_oe | output | 1 | Right drive-enable |

## Verification
The assertions check these rules on every cycle:
- output-enable gating on both ports;
- the drive-enable that follows selected reads, deselected cycles and writes in flow-through mode;
- the counter's clear, load, hold and wrapping step, observed through the internal address.

Only the bench's scenarios can show the stored contents, in particular:
- the left-wins rule for same-address writes;
- old-data returns when one port reads what the other writes;
- the pipelined one-cycle delay of the data word.

A behavioural reference model checks each of these against the outputs on every clock, over directed sequences and a random run confined to a small address window so that collisions are frequent.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    typedef enum logic [1:0] {
        CNT_CLEAR,
        CNT_LOAD,
        CNT_HOLD,
        CNT_STEP
    } cnt_op_e;

    function automatic cnt_op_e pick_cnt_op(input logic clr_n, input logic ld_n, input logic en_n);
        if (!clr_n)     return CNT_CLEAR;
        else if (!ld_n) return CNT_LOAD;
        else if (en_n)  return CNT_HOLD;
        else            return CNT_STEP;
    endfunction

endpackage

// File: rtl/dpr_burst_ctr.sv
module dpr_burst_ctr
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              ld_n,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] int_addr
);

    cnt_op_e           op;
    logic [ADDR_W-1:0] cnt_q;
    logic [ADDR_W-1:0] cnt_d;

    always_comb begin
        op = pick_cnt_op(clr_n, ld_n, en_n);
        unique case (op)
            CNT_CLEAR: cnt_d = '0;
            CNT_LOAD:  cnt_d = ext_addr;
            CNT_HOLD:  cnt_d = cnt_q;
            CNT_STEP:  cnt_d = cnt_q + 1'b1;
            default:   cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign int_addr = cnt_d;

endmodule

// File: rtl/dpr_array.sv
module dpr_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic                   clk,
    input  logic [1:0]             rd_en,
    input  logic [1:0]             wr_en,
    input  logic [1:0][ADDR_W-1:0] ia,
    input  logic [1:0][DATA_W-1:0] wd,
    output logic [1:0][DATA_W-1:0] rd_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // reads see pre-edge contents; right is written first so left wins a tie
    always_ff @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (rd_en[p]) rd_q[p] <= mem[ia[p]];
        end
        if (wr_en[1]) mem[ia[1]] <= wd[1];
        if (wr_en[0]) mem[ia[0]] <= wd[0];
    end

endmodule

// File: rtl/dpr_read_path.sv
module dpr_read_path #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_take,
    input  logic [DATA_W-1:0] flow_d,
    input  logic              pipe,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dq,
    output logic              dq_oe
);

    logic              flow_v;
    logic              pipe_v;
    logic [DATA_W-1:0] pipe_d;
    logic              sel_v;
    logic [DATA_W-1:0] sel_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flow_v <= 1'b0;
            pipe_v <= 1'b0;
        end else begin
            flow_v <= rd_take;
            pipe_v <= flow_v;
        end
    end

    always_ff @(posedge clk) begin
        pipe_d <= flow_d;
    end

    always_comb begin
        sel_v = pipe ? pipe_v : flow_v;
        sel_d = pipe ? pipe_d : flow_d;
        dq_oe = sel_v & ~oe_n;
        dq    = dq_oe ? sel_d : '0;
    end

endmodule

// File: rtl/dpr_burst_ram.sv
module dpr_burst_ram #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_rw,
    input  logic              l_ce0_n,
    input  logic              l_ce1,
    input  logic              l_oe_n,
    input  logic              l_pipe,
    input  logic              l_ads_n,
    input  logic              l_cnten_n,
    input  logic              l_cntrst_n,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rdata_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_rw,
    input  logic              r_ce0_n,
    input  logic              r_ce1,
    input  logic              r_oe_n,
    input  logic              r_pipe,
    input  logic              r_ads_n,
    input  logic              r_cnten_n,
    input  logic              r_cntrst_n,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rdata_oe
);

    localparam int NPORT = 2;

    logic [NPORT-1:0][ADDR_W-1:0] addr_v;
    logic [NPORT-1:0][DATA_W-1:0] wd_v;
    logic [NPORT-1:0][DATA_W-1:0] dq_v;
    logic [NPORT-1:0][DATA_W-1:0] flow_v;
    logic [NPORT-1:0][ADDR_W-1:0] ia_v;
    logic [NPORT-1:0]             rw_v, ce0n_v, ce1_v, oen_v, pipe_v;
    logic [NPORT-1:0]             adsn_v, cntenn_v, cntrstn_v;
    logic [NPORT-1:0]             sel_v, rd_v, wr_v, dqoe_v;

    assign addr_v    = {r_addr, l_addr};
    assign wd_v      = {r_wdata, l_wdata};
    assign rw_v      = {r_rw, l_rw};
    assign ce0n_v    = {r_ce0_n, l_ce0_n};
    assign ce1_v     = {r_ce1, l_ce1};
    assign oen_v     = {r_oe_n, l_oe_n};
    assign pipe_v    = {r_pipe, l_pipe};
    assign adsn_v    = {r_ads_n, l_ads_n};
    assign cntenn_v  = {r_cnten_n, l_cnten_n};
    assign cntrstn_v = {r_cntrst_n, l_cntrst_n};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign sel_v[p] = ~ce0n_v[p] & ce1_v[p];
        assign rd_v[p]  = sel_v[p] & rw_v[p];
        assign wr_v[p]  = sel_v[p] & ~rw_v[p];

        dpr_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_n    (cntrstn_v[p]),
            .ld_n     (adsn_v[p]),
            .en_n     (cntenn_v[p]),
            .ext_addr (addr_v[p]),
            .int_addr (ia_v[p])
        );

        dpr_read_path #(.DATA_W(DATA_W)) u_rd (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_take (rd_v[p]),
            .flow_d  (flow_v[p]),
            .pipe    (pipe_v[p]),
            .oe_n    (oen_v[p]),
            .dq      (dq_v[p]),
            .dq_oe   (dqoe_v[p])
        );
    end

    dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rd_en (rd_v),
        .wr_en (wr_v),
        .ia    (ia_v),
        .wd    (wd_v),
        .rd_q  (flow_v)
    );

    assign l_rdata    = dq_v[0];
    assign l_rdata_oe = dqoe_v[0];
    assign r_rdata    = dq_v[1];
    assign r_rdata_oe = dqoe_v[1];

endmodule

// File: rtl/dpr_burst_ram_chk.sv
module dpr_burst_ram_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_rw,
    input logic              l_ce0_n,
    input logic              l_ce1,
    input logic              l_oe_n,
    input logic              l_pipe,
    input logic              l_ads_n,
    input logic              l_cnten_n,
    input logic              l_cntrst_n,
    input logic              l_rdata_oe,
    input logic              r_oe_n,
    input logic              r_rdata_oe,
    input logic [ADDR_W-1:0] l_ia
);

    logic up = 1'b0;
    always_ff @(posedge clk) up <= rst_n;

    logic l_sel, l_hold, l_step;
    assign l_sel  = !l_ce0_n && l_ce1;
    assign l_hold = l_cntrst_n && l_ads_n && l_cnten_n;
    assign l_step = l_cntrst_n && l_ads_n && !l_cnten_n;

    a_r6_left_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        l_oe_n |-> !l_rdata_oe);
    a_r6_right_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        r_oe_n |-> !r_rdata_oe);
    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !l_sel |=> (l_pipe || !l_rdata_oe));
    a_r3_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && !l_rw) |=> (l_pipe || !l_rdata_oe));
    a_r4_flow_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && l_rw) |=> (l_pipe || l_oe_n || l_rdata_oe));
    a_r7_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        !l_cntrst_n |=> (!l_hold || l_ia == '0));
    a_r8_load_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (l_cntrst_n && !l_ads_n) |=> (!l_hold || l_ia == $past(l_addr)));
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (up && l_hold) |-> l_ia == $past(l_ia));
    a_r10_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (up && l_step) |-> l_ia == ADDR_W'($past(l_ia) + 1'b1));

endmodule

bind dpr_burst_ram dpr_burst_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .l_addr     (l_addr),
    .l_rw       (l_rw),
    .l_ce0_n    (l_ce0_n),
    .l_ce1      (l_ce1),
    .l_oe_n     (l_oe_n),
    .l_pipe     (l_pipe),
    .l_ads_n    (l_ads_n),
    .l_cnten_n  (l_cnten_n),
    .l_cntrst_n (l_cntrst_n),
    .l_rdata_oe (l_rdata_oe),
    .r_oe_n     (r_oe_n),
    .r_rdata_oe (r_rdata_oe),
    .l_ia       (ia_v[0])
);

// File: tb/dpr_burst_ram_tb.sv
module dpr_burst_ram_tb;

    localparam int AW   = 11;
    localparam int DW   = 9;
    localparam int AMAX = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [AW-1:0] b_addr [2];
    logic [DW-1:0] b_wd [2];
    logic          b_rw [2], b_ce0n [2], b_ce1 [2], b_oen [2], b_pipe [2];
    logic          b_adsn [2], b_cntenn [2], b_cntrstn [2];
    logic [DW-1:0] o_dq [2];
    logic          o_oe [2];

    dpr_burst_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_addr(b_addr[0]), .l_wdata(b_wd[0]), .l_rw(b_rw[0]), .l_ce0_n(b_ce0n[0]),
        .l_ce1(b_ce1[0]), .l_oe_n(b_oen[0]), .l_pipe(b_pipe[0]), .l_ads_n(b_adsn[0]),
        .l_cnten_n(b_cntenn[0]), .l_cntrst_n(b_cntrstn[0]),
        .l_rdata(o_dq[0]), .l_rdata_oe(o_oe[0]),
        .r_addr(b_addr[1]), .r_wdata(b_wd[1]), .r_rw(b_rw[1]), .r_ce0_n(b_ce0n[1]),
        .r_ce1(b_ce1[1]), .r_oe_n(b_oen[1]), .r_pipe(b_pipe[1]), .r_ads_n(b_adsn[1]),
        .r_cnten_n(b_cntenn[1]), .r_cntrst_n(b_cntrstn[1]),
        .r_rdata(o_dq[1]), .r_rdata_oe(o_oe[1])
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R13";

    // behavioural reference model
    int unsigned mmem [int];
    int  m_cnt [2];
    bit  f_v [2], f_k [2], p_v [2], p_k [2];
    int  f_d [2], p_d [2];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_update();
        int  ia [2];
        bit  sel [2];
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin
                m_cnt[p] = 0; f_v[p] = 0; p_v[p] = 0;
            end
            return;
        end
        for (int p = 0; p < 2; p++) begin
            if (!b_cntrstn[p])   ia[p] = 0;
            else if (!b_adsn[p]) ia[p] = int'(b_addr[p]);
            else if (b_cntenn[p]) ia[p] = m_cnt[p];
            else                 ia[p] = (m_cnt[p] + 1) % (AMAX + 1);
            m_cnt[p] = ia[p];
            sel[p] = !b_ce0n[p] && b_ce1[p];
            p_v[p] = f_v[p]; p_d[p] = f_d[p]; p_k[p] = f_k[p];
            f_v[p] = sel[p] && b_rw[p];
            if (f_v[p]) begin
                f_k[p] = mmem.exists(ia[p]);
                f_d[p] = f_k[p] ? int'(mmem[ia[p]]) : 0;
            end
        end
        if (sel[1] && !b_rw[1]) mmem[ia[1]] = b_wd[1];
        if (sel[0] && !b_rw[0]) mmem[ia[0]] = b_wd[0];
    endtask

    task automatic compare();
        for (int p = 0; p < 2; p++) begin
            bit e_oe;
            bit e_k;
            int e_d;
            e_oe = (b_pipe[p] ? p_v[p] : f_v[p]) && !b_oen[p];
            e_k  = b_pipe[p] ? p_k[p] : f_k[p];
            e_d  = b_pipe[p] ? p_d[p] : f_d[p];
            chk(o_oe[p] == e_oe, cur_req, int'(o_oe[p]), int'(e_oe));
            if (e_oe && e_k) chk(int'(o_dq[p]) == e_d, cur_req, int'(o_dq[p]), e_d);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic setp(input int p, input bit ce0n, input bit ce1, input bit rw,
                        input bit adsn, input bit cntenn, input bit cntrstn,
                        input int a, input int wd);
        b_ce0n[p] = ce0n; b_ce1[p] = ce1; b_rw[p] = rw;
        b_adsn[p] = adsn; b_cntenn[p] = cntenn; b_cntrstn[p] = cntrstn;
        b_addr[p] = AW'(a); b_wd[p] = DW'(wd);
    endtask

    task automatic idle(input int p);
        setp(p, 1, 0, 1, 1, 1, 1, 0, 0);
    endtask

    task automatic expect_rd(input int p, input int exp, input string req);
        chk(o_oe[p] == 1'b1 && int'(o_dq[p]) == exp, req, int'(o_dq[p]), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            idle(p); b_oen[p] = 0; b_pipe[p] = 0;
        end
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R13: nothing driven after reset
        chk(o_oe[0] == 0 && o_oe[1] == 0, "R13", int'(o_oe[0]), 0);
        // R13: right hold-mode write lands at address 0
        setp(1, 0, 1, 0, 1, 1, 1, 5, 'h1A5); cyc(); idle(1);
        setp(0, 0, 1, 1, 0, 1, 1, 0, 0); cyc();
        expect_rd(0, 'h1A5, "R13");

        // R3 and R8: loaded writes, 16..31
        cur_req = "R8";
        for (int i = 0; i < 16; i++) begin
            setp(0, 0, 1, 0, 0, 1, 1, 16 + i, i * 7 + 3); cyc();
        end
        // R4 and R7: flow-through burst from 16
        cur_req = "R4";
        setp(0, 0, 1, 1, 0, 1, 1, 16, 0); cyc();
        expect_rd(0, 3, "R4");
        for (int i = 1; i <= 4; i++) begin
            setp(0, 0, 1, 1, 1, 0, 1, 0, 0); cyc();
            expect_rd(0, i * 7 + 3, "R7");
        end
        setp(0, 0, 1, 1, 1, 1, 1, 999, 0); cyc();
        expect_rd(0, 4 * 7 + 3, "R7");
        // R3: a write cycle does not drive
        setp(0, 0, 1, 0, 1, 1, 1, 0, 4 * 7 + 3); cyc();
        chk(o_oe[0] == 0, "R3", int'(o_oe[0]), 0);
        idle(0);

        // R5: pipelined right reads from 18
        cur_req = "R5";
        b_pipe[1] = 1;
        setp(1, 0, 1, 1, 0, 1, 1, 18, 0); cyc();
        chk(o_oe[1] == 0, "R5", int'(o_oe[1]), 0);
        setp(1, 0, 1, 1, 1, 0, 1, 0, 0); cyc();
        expect_rd(1, 2 * 7 + 3, "R5");
        idle(1); cyc();
        expect_rd(1, 3 * 7 + 3, "R5");
        b_pipe[1] = 0;
        cyc();

        // R9: clear beats load and reads address 0 in the same cycle
        cur_req = "R9";
        setp(0, 0, 1, 1, 0, 0, 0, 21, 0); cyc();
        expect_rd(0, 'h1A5, "R9");
        setp(0, 0, 1, 1, 1, 1, 1, 21, 0); cyc();
        expect_rd(0, 'h1A5, "R7");

        // R10: step from the top address wraps to 0
        cur_req = "R10";
        setp(0, 0, 1, 0, 0, 1, 1, AMAX, 'h0F0); cyc();
        setp(0, 0, 1, 0, 1, 0, 1, 0, 'h10F); cyc();
        idle(0);
        setp(1, 0, 1, 1, 0, 1, 1, AMAX, 0); cyc();
        expect_rd(1, 'h0F0, "R10");
        setp(1, 0, 1, 1, 1, 0, 1, 0, 0); cyc();
        expect_rd(1, 'h10F, "R10");
        idle(1);

        // R2: either chip enable inactive blocks the write
        cur_req = "R2";
        setp(0, 1, 1, 0, 0, 1, 1, 16, 'h111); cyc();
        setp(0, 0, 0, 0, 0, 1, 1, 16, 'h122); cyc();
        setp(0, 1, 1, 1, 0, 1, 1, 16, 0); cyc();
        chk(o_oe[0] == 0, "R2", int'(o_oe[0]), 0);
        setp(0, 0, 1, 1, 0, 1, 1, 16, 0); cyc();
        expect_rd(0, 3, "R2");

        // R6: output enable gates combinationally
        cur_req = "R6";
        b_oen[0] = 1;
        setp(0, 0, 1, 1, 0, 1, 1, 17, 0); cyc();
        chk(o_oe[0] == 0 && o_dq[0] == 0, "R6", int'(o_dq[0]), 0);
        b_oen[0] = 0; #1;
        expect_rd(0, 10, "R6");
        idle(0);

        // R11: same-address double write, left wins
        cur_req = "R11";
        setp(0, 0, 1, 0, 0, 1, 1, 40, 'h0AA);
        setp(1, 0, 1, 0, 0, 1, 1, 40, 'h155); cyc();
        idle(1);
        setp(0, 0, 1, 1, 0, 1, 1, 40, 0); cyc();
        expect_rd(0, 'h0AA, "R11");

        // R12: read during the other port's write gives old data
        cur_req = "R12";
        setp(0, 0, 1, 0, 0, 1, 1, 41, 'h033); cyc();
        setp(0, 0, 1, 0, 0, 1, 1, 41, 'h0CC);
        setp(1, 0, 1, 1, 0, 1, 1, 41, 0); cyc();
        expect_rd(1, 'h033, "R12");
        idle(0); cyc();
        expect_rd(1, 'h0CC, "R12");
        idle(1);

        // R1: random concurrent traffic on a small window
        cur_req = "R1";
        for (int n = 0; n < 600; n++) begin
            for (int p = 0; p < 2; p++) begin
                setp(p, $urandom_range(0, 7) == 0, $urandom_range(0, 7) != 0,
                     $urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0,
                     $urandom_range(0, 1) == 1, $urandom_range(0, 15) != 0,
                     $urandom_range(0, 63), $urandom_range(0, (1 << DW) - 1));
                b_oen[p]  = $urandom_range(0, 7) == 0;
                b_pipe[p] = $urandom_range(0, 1) == 1;
            end
            cyc();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule